// File: doc/BRIEF.md
# Prioritised Access Permission Checker

This block decides whether a single memory access may proceed. A requester presents the byte address, the access size in bytes, the set of wanted permissions (read, write, execute) and the current privilege mode. Alongside it, the surrounding logic supplies a table of protection entries. Each entry carries inclusive lower and upper byte bounds, a configuration byte and a lock flag. The block works out the first and last byte the access touches. It walks the entries from the lowest index upward and lets the first entry that can decide the access settle it.

A request is presented with a one-cycle valid strobe. Exactly one cycle later the block raises a one-cycle done pulse together with the allow/deny verdict, a flag telling whether an entry decided the verdict, and that entry's index for debug. A request whose size is zero is treated as an access of a fixed default length. Computing the bounds and writing the entry registers are handled elsewhere.

Configuration byte layout: bit 0 grants read, bit 1 grants write, bit 2 grants execute, and bits 4:3 hold the matching mode, where 0 means the entry is switched off and any other value means it is active. Wanted permissions use the same bit order. The privilege mode is 2 bits wide, and the value 3 is machine mode.

Top module: `prio_perm_check`

## Requirements
- R1: After reset, and in every cycle that does not follow a valid strobe, the done output is low.
- R2: When no entry is active (all match-mode fields are 0), a machine-mode (mode 3) access is allowed and an access in any other mode is denied, with the hit flag low.
- R3: Entries are examined in ascending index order, and the lowest-indexed entry that decides the access sets the verdict and the reported index.
- R4: An active entry decides the access if exactly one of the first byte (address) and the last byte (address + size - 1) lies inside its inclusive bounds. The access is then denied, in every mode.
- R5: An active entry that holds both end bytes decides the access. The access is allowed only if every wanted permission bit (bit 0 R, bit 1 W, bit 2 X) is set among the entry's granted bits.
- R6: A deciding entry grants read, write and execute to a machine-mode access when its lock flag is low. When the lock flag is high, or the mode is not 3, it grants only the permission bits 2:0 of its configuration.
- R7: When at least one entry is active but none decides the access, machine mode is allowed, other modes are denied, and the hit flag is low.
- R8: A request with size 0 is checked as an access of DEF_SIZE bytes.
- R9: The verdict, hit flag and index appear with a one-cycle done pulse on the clock edge after the one that samples the valid strobe. The index is 0 when the hit flag is low.
- R10: An entry whose match-mode field is 0 never decides an access, even when its bounds cut through the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_addr | input | AW | Byte address of the first byte |
| req_size | input | SW | Access length in bytes, 0 selects DEF_SIZE |
| req_want | input | 3 | Wanted permissions (bit0 R, bit1 W, bit2 X) |
| req_mode | input | 2 | Privilege mode, 3 is machine mode |
| ent_lo | input | N*AW | Inclusive lower bound per entry, entry i at bits i*AW |
| ent_hi | input | N*AW | Inclusive upper bound per entry |
| ent_cfg | input | N*8 | Configuration byte per entry |
| ent_lock | input | N | Lock flag per entry |
| rsp_done | output | 1 | Result valid pulse |
| rsp_allow | output | 1 | Access allowed |
| rsp_hit | output | 1 | An entry decided the verdict |
| rsp_idx | output | IW | Index of the deciding entry |

## Verification
On every cycle, the assertions check the done-pulse timing, the default verdicts when no entry is active, and that an allowed non-machine access always carries a hit. Which entry wins when regions overlap, the denial of straddling accesses, the effect of the lock flag on machine mode, the substitution of the default size, and the rule that disabled entries are ignored all depend on particular entry tables. Only the bench's directed scenarios and its randomised sweep show those, against its behavioural model.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;
  typedef logic [2:0] perm_t;
  localparam logic [1:0] MODE_MACH = 2'd3;
  localparam logic [1:0] MATCH_OFF = 2'd0;
  localparam perm_t      PERM_ALL  = 3'b111;

  function automatic logic perm_covers(input perm_t granted, input perm_t want);
    return (want & granted) == want;
  endfunction
endpackage

// File: rtl/perm_entry_eval.sv
module perm_entry_eval
  import perm_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] first_b,
  input  logic [AW-1:0] last_b,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [7:0]    cfg,
  input  logic          lock,
  input  logic [1:0]    mode,
  input  perm_t         want,
  output logic          active,
  output logic          decide,
  output logic          pass
);
  logic  in_first, in_last;
  perm_t granted;

  always_comb begin
    active   = cfg[4:3] != MATCH_OFF;
    in_first = (first_b >= lo) && (first_b <= hi);
    in_last  = (last_b  >= lo) && (last_b  <= hi);
    granted  = (mode == MODE_MACH && !lock) ? PERM_ALL : perm_t'(cfg[2:0]);
    // straddle (one end in) or full containment both settle the access
    decide   = active && (in_first || in_last);
    pass     = active && in_first && in_last && perm_covers(granted, want);
  end
endmodule

// File: rtl/perm_first_pick.sv
module perm_first_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  decide,
  input  logic [N-1:0]  pass,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic          pass_sel
);
  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    pass_sel = 1'b0;
    // descending walk so the lowest deciding index is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (decide[i]) begin
        hit      = 1'b1;
        idx      = IW'(i);
        pass_sel = pass[i];
      end
    end
  end
endmodule

// File: rtl/prio_perm_check.sv
module prio_perm_check
  import perm_chk_pkg::*;
#(
  parameter int N        = 8,
  parameter int AW       = 32,
  parameter int SW       = 8,
  parameter int DEF_SIZE = 4,
  localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_size,
  input  logic [2:0]    req_want,
  input  logic [1:0]    req_mode,
  input  logic [N*AW-1:0] ent_lo,
  input  logic [N*AW-1:0] ent_hi,
  input  logic [N*8-1:0]  ent_cfg,
  input  logic [N-1:0]    ent_lock,
  output logic          rsp_done,
  output logic          rsp_allow,
  output logic          rsp_hit,
  output logic [IW-1:0] rsp_idx
);
  logic [AW-1:0] eff_size, last_b;
  logic [N-1:0]  act_v, dec_v, pass_v;
  logic          any_act, hit_c, pass_c, allow_c;
  logic [IW-1:0] idx_c;

  always_comb begin
    eff_size = (req_size == '0) ? AW'(DEF_SIZE) : AW'(req_size);
    last_b   = req_addr + eff_size - AW'(1);
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    perm_entry_eval #(.AW(AW)) u_eval (
      .first_b (req_addr),
      .last_b  (last_b),
      .lo      (ent_lo[g*AW +: AW]),
      .hi      (ent_hi[g*AW +: AW]),
      .cfg     (ent_cfg[g*8 +: 8]),
      .lock    (ent_lock[g]),
      .mode    (req_mode),
      .want    (perm_t'(req_want)),
      .active  (act_v[g]),
      .decide  (dec_v[g]),
      .pass    (pass_v[g])
    );
  end

  perm_first_pick #(.N(N), .IW(IW)) u_pick (
    .decide   (dec_v),
    .pass     (pass_v),
    .hit      (hit_c),
    .idx      (idx_c),
    .pass_sel (pass_c)
  );

  always_comb begin
    any_act = |act_v;
    if (hit_c) allow_c = pass_c;
    else       allow_c = (req_mode == MODE_MACH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_done <= req_valid;
      if (req_valid) begin
        rsp_allow <= allow_c;
        rsp_hit   <= hit_c;
        rsp_idx   <= idx_c;
      end
    end
  end

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_done); // R9
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_done); // R1
  AST_EMPTY_MACH_OK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !any_act && req_mode == MODE_MACH) |=> (rsp_allow && !rsp_hit)); // R2
  AST_EMPTY_OTHER_NO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !any_act && req_mode != MODE_MACH) |=> (!rsp_allow && !rsp_hit)); // R2
  AST_NONMACH_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode != MODE_MACH) |=> (!rsp_allow || rsp_hit)); // R7
  AST_IDX_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && !rsp_hit) |-> (rsp_idx == '0)); // R9
endmodule

// File: tb/sim_prio_perm_check.sv
module sim_prio_perm_check;
  localparam int N = 8, AW = 32, SW = 8, DEF = 4, IW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic [2:0]    req_want = '0;
  logic [1:0]    req_mode = '0;
  logic [AW-1:0] lo [N];
  logic [AW-1:0] hi [N];
  logic [7:0]    cfg [N];
  logic [N-1:0]  lck = '0;
  logic [N*AW-1:0] lo_f, hi_f;
  logic [N*8-1:0]  cfg_f;
  logic          rsp_done, rsp_allow, rsp_hit;
  logic [IW-1:0] rsp_idx;

  always_comb
    for (int i = 0; i < N; i++) begin
      lo_f[i*AW +: AW] = lo[i];
      hi_f[i*AW +: AW] = hi[i];
      cfg_f[i*8 +: 8]  = cfg[i];
    end

  prio_perm_check #(.N(N), .AW(AW), .SW(SW), .DEF_SIZE(DEF)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_want(req_want), .req_mode(req_mode),
    .ent_lo(lo_f), .ent_hi(hi_f), .ent_cfg(cfg_f), .ent_lock(lck),
    .rsp_done(rsp_done), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx));

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  logic e_done = 0, e_allow = 0, e_hit = 0;
  int   e_idx = 0;

  // behavioural reference: verdict for current inputs
  task automatic model(output logic al, output logic ht, output int ix);
    longint unsigned a, l, sz;
    bit any = 0, done = 0;
    sz = (req_size == 0) ? DEF : req_size;
    a  = req_addr;
    l  = (a + sz - 1) & 64'hFFFF_FFFF;
    al = (req_mode == 2'd3); ht = 0; ix = 0;
    for (int i = 0; i < N; i++) begin
      bit f, t;
      if (cfg[i][4:3] == 0) continue;
      any = 1;
      if (done) continue;
      f = (a >= lo[i]) && (a <= hi[i]);
      t = (l >= lo[i]) && (l <= hi[i]);
      if (f != t) begin al = 0; ht = 1; ix = i; done = 1; end
      else if (f && t) begin
        logic [2:0] g;
        g = (req_mode == 2'd3 && !lck[i]) ? 3'b111 : cfg[i][2:0];
        al = ((req_want & g) == req_want); ht = 1; ix = i; done = 1;
      end
    end
    if (!any) begin al = (req_mode == 2'd3); ht = 0; ix = 0; end
  endtask

  always @(posedge clk) begin
    logic al, ht; int ix;
    if (rst) e_done <= 0;
    else begin
      e_done <= req_valid;
      if (req_valid) begin
        model(al, ht, ix);
        e_allow <= al; e_hit <= ht; e_idx <= ix;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (!rst) begin
      n_cmp++;
      if (rsp_done !== e_done) begin
        n_bad++;
        $display("FAIL %s done act=%0b exp=%0b", tag, rsp_done, e_done);
      end else if (e_done && (rsp_allow !== e_allow || rsp_hit !== e_hit || int'(rsp_idx) != e_idx)) begin
        n_bad++;
        $display("FAIL %s allow/hit/idx act=%0b/%0b/%0d exp=%0b/%0b/%0d",
                 tag, rsp_allow, rsp_hit, rsp_idx, e_allow, e_hit, e_idx);
      end
    end
  end

  task automatic set_ent(int i, int l, int h, logic [7:0] c, logic k);
    lo[i] = l; hi[i] = h; cfg[i] = c; lck[i] = k;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) set_ent(i, 0, 0, 8'h00, 0);
  endtask

  task automatic req(string t, int a, int s, logic [2:0] w, logic [1:0] m);
    @(negedge clk);
    tag = t; req_addr = a; req_size = s; req_want = w; req_mode = m; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  bit finished = 0;
  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    repeat (3) @(negedge clk);
    // R2: nothing active
    req("R2", 16, 4, 3'b001, 2'd3);
    req("R2", 16, 4, 3'b001, 2'd0);
    // R3: overlapping entries, lowest index wins
    set_ent(2, 0, 63, 8'h08 | 8'h01, 0);
    set_ent(5, 0, 63, 8'h08 | 8'h07, 0);
    req("R3", 8, 4, 3'b010, 2'd0);
    req("R3", 8, 4, 3'b001, 2'd0);
    // R4: straddle denied even in machine mode
    req("R4", 62, 4, 3'b001, 2'd3);
    req("R4", 62, 4, 3'b001, 2'd0);
    // R5: permission subset
    clear_all();
    set_ent(1, 100, 199, 8'h18 | 8'h05, 0);
    req("R5", 120, 8, 3'b101, 2'd1);
    req("R5", 120, 8, 3'b011, 2'd1);
    req("R5", 120, 8, 3'b000, 2'd0);
    // R6: machine bypass only when unlocked
    set_ent(1, 100, 199, 8'h10 | 8'h00, 0);
    req("R6", 150, 4, 3'b111, 2'd3);
    set_ent(1, 100, 199, 8'h10 | 8'h00, 1);
    req("R6", 150, 4, 3'b001, 2'd3);
    set_ent(1, 100, 199, 8'h10 | 8'h02, 1);
    req("R6", 150, 4, 3'b010, 2'd3);
    // R7: active rules, no match
    req("R7", 300, 4, 3'b001, 2'd3);
    req("R7", 300, 4, 3'b001, 2'd1);
    // R8: zero size uses default
    clear_all();
    set_ent(0, 0, 33, 8'h08 | 8'h07, 0);
    req("R8", 32, 0, 3'b001, 2'd0);
    req("R8", 32, 2, 3'b001, 2'd0);
    req("R8", 30, 0, 3'b001, 2'd0);
    // R10: disabled entry with straddling bounds ignored
    set_ent(0, 0, 33, 8'h07, 0);
    set_ent(3, 0, 99, 8'h18 | 8'h01, 0);
    req("R10", 32, 4, 3'b001, 2'd0);
    // R9: back-to-back strobes and index reporting
    set_ent(6, 200, 255, 8'h08 | 8'h04, 0);
    @(negedge clk);
    tag = "R9"; req_valid = 1; req_addr = 210; req_size = 4; req_want = 3'b100; req_mode = 2'd0;
    @(negedge clk);
    req_addr = 10;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    // random sweep
    tag = "R3";
    for (int k = 0; k < 400; k++) begin
      if (k % 20 == 0)
        for (int i = 0; i < N; i++) begin
          int a, b;
          a = $urandom_range(0, 255); b = $urandom_range(0, 255);
          set_ent(i, (a < b) ? a : b, (a < b) ? b : a,
                  8'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
        end
      @(negedge clk);
      req_valid = 1'($urandom_range(0, 3) != 0);
      req_addr  = $urandom_range(0, 255);
      req_size  = 8'($urandom_range(0, 9));
      req_want  = 3'($urandom_range(0, 7));
      req_mode  = 2'($urandom_range(0, 3));
    end
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule